// File: doc/BRIEF.md
# Parallel-to-Serial FIFO with Occupancy Flags

This block buffers 9-bit words that arrive on a parallel write port and sends them out one bit at a time, least significant bit first. Storage is a power-of-two number of words (2048 by default). Each time the serial shifter becomes idle and a word is stored, the oldest word moves into the shifter and leaves storage. A two-bit length code, sampled at that moment, selects how many bits of the word go out.

Both data interfaces use valid/ready. A writer may hold `wr_valid` high for as long as it wants. A word is taken only on a clock edge where `wr_ready` is also high, and `wr_ready` falls when storage is full. On the serial side, `bit_valid` and `bit_data` stay fixed until the consumer raises `bit_ready`. Nothing is lost when the consumer stalls.

Four active-low status outputs report storage occupancy: full, empty, over half, and a combined flag for the bottom eighth or the top eighth. A rewind command moves the read location back to the start of memory, so the stored data can be sent again. All flags are registers that change on the same edge as the occupancy count.

Top module: `pts_fifo`

## Requirements
- R1: While `rst_n` is low, the outputs are `full_n`=1, `half_n`=1, `empty_n`=0, `edge_n`=0, `wr_ready`=1 and `bit_valid`=0. Both memory locations and the count return to zero.
- R2: `wr_ready` is high exactly when fewer than DEPTH words are stored. A word is stored on an edge where `wr_valid` and `wr_ready` are both high. A write request while storage is full changes nothing.
- R3: Words leave in the order they were written. Each word is sent least significant bit first, one bit per `bit_valid`/`bit_ready` handshake.
- R4: `word_len` is sampled when a word enters the shifter: 2'b00 sends 5 bits, 2'b01 sends 7, 2'b10 sends 8 and 2'b11 sends 9. The remaining upper bits are dropped.
- R5: While `bit_valid` is high and `bit_ready` is low, `bit_valid` and `bit_data` hold. The oldest word moves into the shifter on the first edge where the shifter is idle and at least one word is stored, and the stored count drops by one on that edge.
- R6: `empty_n` is low exactly when no words are stored, and no word enters the shifter then.
- R7: `full_n` is low exactly when DEPTH words are stored.
- R8: `half_n` is low exactly when more than DEPTH/2 words are stored (1025 or more at 2048).
- R9: `edge_n` is low when fewer than DEPTH/8 words are stored, or more than DEPTH-DEPTH/8. At 2048 that means 0–255 or 1793–2048 words.
- R10: A `rewind` pulse is taken only in a cycle with no stored write and no shifter load. It sets the read location to 0 and leaves the write location unchanged. The count then becomes the write location, or DEPTH when the write location is 0 and the count was nonzero. Otherwise the pulse is ignored.
- R11: Every flag takes its new value on the same clock edge as the occupancy change that causes it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_valid | input | 1 | Write word offered |
| wr_ready | output | 1 | Storage can take a word |
| wr_data | input | 9 | Parallel write word |
| word_len | input | 2 | Serial length code, sampled at shifter load |
| rewind | input | 1 | Replay request: read location back to 0 |
| bit_valid | output | 1 | Serial bit offered |
| bit_ready | input | 1 | Consumer takes the serial bit |
| bit_data | output | 1 | Serial bit, LSB first |
| full_n | output | 1 | Low when storage is full |
| empty_n | output | 1 | Low when storage is empty |
| half_n | output | 1 | Low when over half full |
| edge_n | output | 1 | Low in the bottom or top eighth of occupancy |

## Verification
A wrong count appears within one cycle as a flag that disagrees with the number of accepted writes minus shifter loads. It can also appear as `wr_ready` falling early or late at the full boundary. A wrong read location, or a bad rewind recompute, appears at `bit_data` on the next word loaded into the shifter, within at most 9 handshakes. A shifter fault appears on the very bit it corrupts. The bench compares every output against a behavioural queue model on every cycle, so each of these faults is reported in the cycle it first reaches a port.

// File: rtl/pts_fifo_pkg.sv
package pts_fifo_pkg;

  typedef struct packed {
    logic full_n;
    logic empty_n;
    logic half_n;
    logic edge_n;
  } occ_flags_t;

  localparam occ_flags_t FLAGS_RESET = '{full_n: 1'b1, empty_n: 1'b0, half_n: 1'b1, edge_n: 1'b0};

  // Serial length for a code: the full width and three shorter taps.
  function automatic int unsigned len_of(input logic [1:0] code, input int unsigned full_w);
    case (code)
      2'b00:   return full_w - 4;
      2'b01:   return full_w - 2;
      2'b10:   return full_w - 1;
      default: return full_w;
    endcase
  endfunction

endpackage

// File: rtl/pts_fifo_ram.sv
module pts_fifo_ram #(
  parameter int DATA_W = 9,
  parameter int DEPTH  = 2048,
  localparam int ADDR_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [ADDR_W-1:0] raddr,
  output logic [DATA_W-1:0] rdata
);

  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  // The shifter registers this value, so the read is synchronous overall.
  assign rdata = mem[raddr];

endmodule

// File: rtl/pts_fifo_ctrl.sv
module pts_fifo_ctrl #(
  parameter int DEPTH = 2048,
  localparam int ADDR_W = $clog2(DEPTH),
  localparam int CNT_W  = ADDR_W + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_fire,
  input  logic              pop,
  input  logic              rewind,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [ADDR_W-1:0] rd_addr,
  output logic              rew_ok,
  output logic [CNT_W-1:0]  count,
  output logic [CNT_W-1:0]  count_next
);

  logic [CNT_W-1:0] rew_count;

  always_comb begin
    rew_ok    = rewind & ~wr_fire & ~pop;
    // Replay covers location 0 up to the write location; a wrapped write
    // location of 0 with data present means the whole memory.
    rew_count = (wr_addr == '0 && count != '0) ? CNT_W'(DEPTH) : {1'b0, wr_addr};
    if (rew_ok) count_next = rew_count;
    else        count_next = count + CNT_W'(wr_fire) - CNT_W'(pop);
  end

  // DEPTH is a power of two, so the address registers wrap on their own.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_addr <= '0;
      rd_addr <= '0;
      count   <= '0;
    end else begin
      wr_addr <= wr_addr + ADDR_W'(wr_fire);
      rd_addr <= rew_ok ? '0 : rd_addr + ADDR_W'(pop);
      count   <= count_next;
    end
  end

endmodule

// File: rtl/pts_fifo_flags.sv
module pts_fifo_flags
  import pts_fifo_pkg::*;
#(
  parameter int DEPTH = 2048,
  localparam int CNT_W  = $clog2(DEPTH) + 1,
  localparam int EIGHTH = DEPTH / 8,
  localparam int HALF   = DEPTH / 2,
  localparam int UPPER  = DEPTH - EIGHTH
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CNT_W-1:0] count_next,
  output occ_flags_t       flags
);

  occ_flags_t nxt;

  always_comb begin
    nxt.full_n  = (count_next != CNT_W'(DEPTH));
    nxt.empty_n = (count_next != '0);
    nxt.half_n  = ~(count_next > CNT_W'(HALF));
    nxt.edge_n  = ~((count_next < CNT_W'(EIGHTH)) || (count_next > CNT_W'(UPPER)));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flags <= FLAGS_RESET;
    else        flags <= nxt;
  end

endmodule

// File: rtl/pts_fifo_shift.sv
module pts_fifo_shift
  import pts_fifo_pkg::*;
#(
  parameter int DATA_W = 9,
  localparam int LEN_W = $clog2(DATA_W + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [DATA_W-1:0] load_data,
  input  logic [1:0]        word_len,
  input  logic              bit_ready,
  output logic              bit_valid,
  output logic              bit_data,
  output logic              idle
);

  logic [DATA_W-1:0] sh_data;
  logic [LEN_W-1:0]  sh_left;

  assign idle      = (sh_left == '0);
  assign bit_valid = ~idle;
  assign bit_data  = sh_data[0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_data <= '0;
      sh_left <= '0;
    end else if (load) begin
      sh_data <= load_data;
      sh_left <= LEN_W'(len_of(word_len, DATA_W));
    end else if (bit_valid && bit_ready) begin
      sh_data <= sh_data >> 1;
      sh_left <= sh_left - 1'b1;
    end
  end

endmodule

// File: rtl/pts_fifo.sv
module pts_fifo
  import pts_fifo_pkg::*;
#(
  parameter int DATA_W = 9,
  parameter int DEPTH  = 2048,
  localparam int ADDR_W = $clog2(DEPTH),
  localparam int CNT_W  = ADDR_W + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_valid,
  output logic              wr_ready,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [1:0]        word_len,
  input  logic              rewind,
  output logic              bit_valid,
  input  logic              bit_ready,
  output logic              bit_data,
  output logic              full_n,
  output logic              empty_n,
  output logic              half_n,
  output logic              edge_n
);

  occ_flags_t        flags;
  logic              wr_fire, pop, sh_idle, rew_ok;
  logic [ADDR_W-1:0] wr_addr, rd_addr;
  logic [CNT_W-1:0]  count, count_next;
  logic [DATA_W-1:0] rd_word;

  assign full_n   = flags.full_n;
  assign empty_n  = flags.empty_n;
  assign half_n   = flags.half_n;
  assign edge_n   = flags.edge_n;
  assign wr_ready = flags.full_n;
  assign wr_fire  = wr_valid & wr_ready;
  assign pop      = sh_idle & flags.empty_n;

  pts_fifo_ctrl #(.DEPTH(DEPTH)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .wr_fire(wr_fire), .pop(pop), .rewind(rewind),
    .wr_addr(wr_addr), .rd_addr(rd_addr), .rew_ok(rew_ok),
    .count(count), .count_next(count_next)
  );

  pts_fifo_flags #(.DEPTH(DEPTH)) u_flags (
    .clk(clk), .rst_n(rst_n), .count_next(count_next), .flags(flags)
  );

  pts_fifo_ram #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_ram (
    .clk(clk), .we(wr_fire), .waddr(wr_addr), .wdata(wr_data),
    .raddr(rd_addr), .rdata(rd_word)
  );

  pts_fifo_shift #(.DATA_W(DATA_W)) u_shift (
    .clk(clk), .rst_n(rst_n), .load(pop), .load_data(rd_word),
    .word_len(word_len), .bit_ready(bit_ready),
    .bit_valid(bit_valid), .bit_data(bit_data), .idle(sh_idle)
  );

endmodule

// File: rtl/pts_fifo_chk.sv
module pts_fifo_chk #(
  parameter int DEPTH = 2048,
  localparam int ADDR_W = $clog2(DEPTH),
  localparam int CNT_W  = ADDR_W + 1
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wr_valid,
  input logic              full_n,
  input logic              empty_n,
  input logic              half_n,
  input logic              edge_n,
  input logic              bit_valid,
  input logic              bit_ready,
  input logic              bit_data,
  input logic [CNT_W-1:0]  count,
  input logic [ADDR_W-1:0] wr_addr,
  input logic [ADDR_W-1:0] rd_addr,
  input logic              rew_ok
);

  p_no_overflow_r2: assert property (@(posedge clk) disable iff (!rst_n)
    count <= CNT_W'(DEPTH));

  p_full_write_ignored_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!full_n && wr_valid) |=> $stable(wr_addr));

  p_bit_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (bit_valid && !bit_ready) |=> (bit_valid && $stable(bit_data)));

  p_empty_stays_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!empty_n && !(wr_valid && full_n) && !rew_ok) |=> !empty_n);

  p_full_stays_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!full_n && bit_valid && !bit_ready && !rew_ok) |=> !full_n);

  p_full_flags_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !full_n |-> (!half_n && !edge_n));

  p_empty_flags_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !empty_n |-> (!edge_n && half_n));

  p_rewind_r10: assert property (@(posedge clk) disable iff (!rst_n)
    rew_ok |=> (rd_addr == '0 && $stable(wr_addr)));

  p_count_ptrs_r10: assert property (@(posedge clk) disable iff (!rst_n)
    ADDR_W'(wr_addr - rd_addr) == count[ADDR_W-1:0]);

  p_flags_track_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (full_n == (count != CNT_W'(DEPTH))) && (empty_n == (count != '0)));

endmodule

bind pts_fifo pts_fifo_chk #(.DEPTH(DEPTH)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .full_n(full_n),
  .empty_n(empty_n), .half_n(half_n), .edge_n(edge_n),
  .bit_valid(bit_valid), .bit_ready(bit_ready), .bit_data(bit_data),
  .count(count), .wr_addr(wr_addr), .rd_addr(rd_addr), .rew_ok(rew_ok)
);

// File: tb/tb_pts_fifo.sv
module tb_pts_fifo;
  localparam int DEPTH = 2048;
  localparam int DW    = 9;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          wr_valid = 1'b0;
  logic [DW-1:0] wr_data = '0;
  logic [1:0]    word_len = 2'b11;
  logic          rewind = 1'b0;
  logic          bit_ready = 1'b0;
  logic          wr_ready, bit_valid, bit_data, full_n, empty_n, half_n, edge_n;

  always #10 clk = ~clk;

  pts_fifo #(.DATA_W(DW), .DEPTH(DEPTH)) dut (
    .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_ready(wr_ready),
    .wr_data(wr_data), .word_len(word_len), .rewind(rewind),
    .bit_valid(bit_valid), .bit_ready(bit_ready), .bit_data(bit_data),
    .full_n(full_n), .empty_n(empty_n), .half_n(half_n), .edge_n(edge_n)
  );

  // Behavioural reference: memory array, counters, bit queue.
  int mem_m [DEPTH];
  int wr_m, rd_m, cnt, old_wr, ln;
  bit sh_q [$];
  bit wf, pp, rw;
  int n_tests = 0, n_fail = 0;
  bit done = 1'b0;

  function automatic int len_for(input logic [1:0] c);
    case (c)
      2'b00: return 5;
      2'b01: return 7;
      2'b10: return 8;
      default: return 9;
    endcase
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      wr_m = 0; rd_m = 0; cnt = 0;
      sh_q.delete();
    end else begin
      wf = wr_valid && (cnt < DEPTH);
      pp = (sh_q.size() == 0) && (cnt > 0);
      rw = rewind && !wf && !pp;
      old_wr = wr_m;
      if (sh_q.size() > 0 && bit_ready) void'(sh_q.pop_front());
      if (pp) begin
        ln = len_for(word_len);
        for (int i = 0; i < ln; i++) sh_q.push_back(bit'((mem_m[rd_m] >> i) & 1));
        rd_m = (rd_m + 1) % DEPTH;
      end
      if (wf) begin
        mem_m[wr_m] = int'(wr_data);
        wr_m = (wr_m + 1) % DEPTH;
      end
      if (rw) begin
        rd_m = 0;
        cnt = (old_wr == 0 && cnt != 0) ? DEPTH : old_wr;
      end else begin
        cnt = cnt + int'(wf) - int'(pp);
      end
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  // R11: flags are compared in the very cycle the model count moves.
  task automatic compare();
    chk("R2 wr_ready", int'(wr_ready), int'(cnt < DEPTH));
    chk("R7 R11 full_n", int'(full_n), int'(cnt != DEPTH));
    chk("R6 R11 empty_n", int'(empty_n), int'(cnt != 0));
    chk("R8 R11 half_n", int'(half_n), int'(!(cnt > DEPTH / 2)));
    chk("R9 R11 edge_n", int'(edge_n),
        int'(!((cnt < DEPTH / 8) || (cnt > DEPTH - DEPTH / 8))));
    chk("R5 bit_valid", int'(bit_valid), int'(sh_q.size() > 0));
    if (sh_q.size() > 0) chk("R3 R4 R10 bit_data", int'(bit_data), int'(sh_q[0]));
  endtask

  task automatic cyc();
    @(negedge clk);
    compare();
  endtask

  task automatic summary();
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog (all requirements): actual hung expected finish");
      summary();
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: outputs held in reset
    chk("R1 full_n", int'(full_n), 1);
    chk("R1 empty_n", int'(empty_n), 0);
    chk("R1 half_n", int'(half_n), 1);
    chk("R1 edge_n", int'(edge_n), 0);
    chk("R1 wr_ready", int'(wr_ready), 1);
    chk("R1 bit_valid", int'(bit_valid), 0);
    rst_n = 1'b1;

    // Stalled consumer, short burst, then a rewind (R10) while idle.
    for (int i = 0; i < 30; i++) begin
      cyc(); wr_valid = 1'b1; wr_data = DW'($urandom); word_len = 2'b10;
    end
    cyc(); wr_valid = 1'b0;
    cyc(); rewind = 1'b1;
    cyc(); rewind = 1'b0;

    // Drain with every length code (R3, R4), one rewind attempt in flight.
    for (int i = 0; i < 500; i++) begin
      cyc(); bit_ready = 1'b1; word_len = 2'($urandom);
      rewind = (i == 120) || (i == 121);
    end
    rewind = 1'b0;

    // Fill to full with the consumer stalled, then keep pushing (R2, R7-R9).
    bit_ready = 1'b0;
    for (int i = 0; i < 2120; i++) begin
      cyc(); wr_valid = 1'b1; wr_data = DW'($urandom);
    end
    cyc(); wr_valid = 1'b0;

    // Drain to empty with a stuttering consumer (R5, R6).
    for (int i = 0; i < 30000; i++) begin
      cyc(); bit_ready = ($urandom % 4) != 0; word_len = 2'($urandom);
    end

    // Mixed traffic with occasional rewinds (R10).
    for (int i = 0; i < 20000; i++) begin
      cyc();
      wr_valid  = ($urandom % 2) != 0;
      wr_data   = DW'($urandom);
      bit_ready = ($urandom % 3) != 0;
      word_len  = 2'($urandom);
      rewind    = ($urandom % 64) == 0;
    end
    cyc();
    done = 1'b1;
    summary();
    $finish;
  end

endmodule